// File: doc/BRIEF.md
# Register File with Delayed Two-Bit Side Array

This block holds a word-wide register file that sits on a shared data bus. The bus is split into an inbound port, an outbound port and an output enable. A single direction control decides how the array meets the bus. While writing, the array lets go of the bus and stores the inbound word at the presented address on the clock. While reading, it drives the addressed word onto the outbound port. The read is combinational, so the word appears in the same cycle the address does.

A narrow side array runs alongside the main one and keeps the low bits of every stored word. It does not use the live address. A first register stage captures the address, the direction control and the low data bits one clock after they are presented. The side array is written from that stage. Its read result is held in an output register that loads on the following clock. The side view of any access therefore arrives two clocks after the main view.

When the stage-1 entry is a write, the output register takes the written bits directly, so the side output is never stale. Reset clears only the pipeline registers. The contents of both arrays are left alone.

Top module: `rfile_shadow`

## Requirements
- R1: When `wr_en` is 1 on a rising clock, `bus_in` is stored at `addr` in the main array, and a later read of that address returns it.
- R2: While `wr_en` is 1, `bus_oe` is 0 and `bus_out` is all zeros.
- R3: While `wr_en` is 0, `bus_oe` is 1 and `bus_out` equals the word stored at the current `addr` in the same cycle, with no clock edge needed.
- R4: The side array does not see `addr` directly. An address presented before clock edge n reaches the side array's address register at edge n, and its effect on `side_out` appears only after edge n+1.
- R5: A write stores `bus_in[1:0]` (the two least significant bits) into the side array at the write address, one clock after the main array stores the full word.
- R6: For a read presented before edge n, `side_out` shows the side array entry for that address after edge n+1 and holds it until the next edge.
- R7: When the stage-1 entry is a write, `side_out` after the next edge equals the two low bits that the write carried.
- R8: Asserting `rst_n` low (asynchronous, active low) clears `side_out` to 0 and discards a pending stage-1 side write. A write caught this way updates the main array only, and the side entry keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset of the pipeline registers |
| addr | input | 8 | Word address for the main array |
| wr_en | input | 1 | 1 = capture `bus_in`, 0 = drive stored word |
| bus_in | input | 16 | Inbound bus value |
| bus_out | output | 16 | Outbound bus value, zero while not driving |
| bus_oe | output | 1 | High while the array drives the bus |
| side_out | output | 2 | Registered side array read result |

## Verification
The bench builds the block with its default parameters: 8 address bits, 16 data bits and a 2-bit side field. A test of this size can cover every one of the 256 words in each of three arithmetic data patterns. The reads run in a scrambled address order, so consecutive accesses always use different addresses. This exposes any case where the two-clock side pipeline answers for the wrong address. A reset placed between a write and its delayed side update shows that the pending side write is dropped while the main store is kept.

// File: rtl/rfile_pkg.sv
package rfile_pkg;
   typedef enum logic {
      RF_DRIVE   = 1'b0,
      RF_CAPTURE = 1'b1
   } rf_dir_e;

   function automatic rf_dir_e dir_of(input logic wr);
      return wr ? RF_CAPTURE : RF_DRIVE;
   endfunction
endpackage

// File: rtl/rfile_main_array.sv
module rfile_main_array #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              wr_stb,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_stb) begin
         words[wr_addr] <= wr_data;
      end
   end

   assign rd_data = words[rd_addr];
endmodule

// File: rtl/rfile_bus_gate.sv
module rfile_bus_gate
   import rfile_pkg::*;
#(
   parameter int DATA_W = 16
) (
   input  rf_dir_e           dir,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] bus_q,
   output logic              oe
);
   assign oe = (dir == RF_DRIVE);

   for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign bus_q[b] = oe & word[b];
   end
endmodule

// File: rtl/rfile_side_pipe.sv
module rfile_side_pipe #(
   parameter int ADDR_W = 8,
   parameter int SIDE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [SIDE_W-1:0] low_bits,
   output logic [SIDE_W-1:0] side_q
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [ADDR_W-1:0] s1_addr;
   logic              s1_we;
   logic [SIDE_W-1:0] s1_bits;
   logic [SIDE_W-1:0] cells [DEPTH];

   // stage 1: registered address, write enable and low data bits
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_addr <= '0;
         s1_we   <= 1'b0;
         s1_bits <= '0;
      end else begin
         s1_addr <= addr;
         s1_we   <= wr_en;
         s1_bits <= low_bits;
      end
   end

   // side storage, written from stage 1
   always_ff @(posedge clk) begin
      if (s1_we) begin
         cells[s1_addr] <= s1_bits;
      end
   end

   // stage 2: registered read, taking the written bits on a write
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         side_q <= '0;
      end else if (s1_we) begin
         side_q <= s1_bits;
      end else begin
         side_q <= cells[s1_addr];
      end
   end
endmodule

// File: rtl/rfile_shadow.sv
module rfile_shadow
   import rfile_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int SIDE_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] bus_in,
   output logic [DATA_W-1:0] bus_out,
   output logic              bus_oe,
   output logic [SIDE_W-1:0] side_out
);
   initial begin
      if (SIDE_W < 1 || SIDE_W > DATA_W) $fatal(1, "SIDE_W out of range");
      if (ADDR_W < 1 || ADDR_W > 12)     $fatal(1, "ADDR_W out of range");
   end

   logic [DATA_W-1:0] rd_word;
   rf_dir_e           dir;

   assign dir = dir_of(wr_en);

   rfile_main_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_main (
      .clk     (clk),
      .wr_stb  (wr_en),
      .wr_addr (addr),
      .wr_data (bus_in),
      .rd_addr (addr),
      .rd_data (rd_word)
   );

   rfile_bus_gate #(.DATA_W(DATA_W)) u_gate (
      .dir   (dir),
      .word  (rd_word),
      .bus_q (bus_out),
      .oe    (bus_oe)
   );

   rfile_side_pipe #(.ADDR_W(ADDR_W), .SIDE_W(SIDE_W)) u_side (
      .clk      (clk),
      .rst_n    (rst_n),
      .addr     (addr),
      .wr_en    (wr_en),
      .low_bits (bus_in[SIDE_W-1:0]),
      .side_q   (side_out)
   );
endmodule

// File: rtl/rfile_shadow_chk.sv
module rfile_shadow_chk #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 16,
   parameter int SIDE_W = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic [DATA_W-1:0] bus_in,
   input logic [DATA_W-1:0] bus_out,
   input logic              bus_oe,
   input logic [SIDE_W-1:0] side_out
);
   AST_WRITE_RELEASES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (!bus_oe && bus_out == '0));                                  // R2

   AST_READ_DRIVES_BUS: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |-> bus_oe);                                                     // R3

   AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en ##1 (!wr_en && addr == $past(addr)) |-> bus_out == $past(bus_in)); // R1

   AST_SIDE_WRITE_THRU: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> ##2 (side_out == $past(bus_in[SIDE_W-1:0], 2)));              // R7

   AST_SIDE_RESET_CLEAR: assert property (@(posedge clk)
      !rst_n |-> side_out == '0);                                             // R8
endmodule

bind rfile_shadow rfile_shadow_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SIDE_W(SIDE_W)
) u_chk (.*);

// File: tb/rfile_shadow_tb.sv
module rfile_shadow_tb;
   localparam int AW = 8;
   localparam int DW = 16;
   localparam int SW = 2;
   localparam int DEPTH = 1 << AW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr = '0;
   logic          wr_en = 1'b0;
   logic [DW-1:0] bus_in = '0;
   logic [DW-1:0] bus_out;
   logic          bus_oe;
   logic [SW-1:0] side_out;

   int checks = 0;
   int fails  = 0;
   logic [DW-1:0] main_m [DEPTH];
   logic [SW-1:0] side_m [DEPTH];

   always #5 clk = ~clk;

   rfile_shadow u_dut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .side_out(side_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [DW-1:0] pat(input int p, input int a);
      return DW'((a * 40503 + p * 4660 + (a << 9)) ^ (p * 21845));
   endfunction

   function automatic int scr(input int k);
      return (k * 37 + 11) % DEPTH;
   endfunction

   task automatic wr(input int a, input logic [DW-1:0] d);
      @(negedge clk);
      addr = AW'(a); wr_en = 1'b1; bus_in = d;
      #1;
      if (a % 64 == 0) begin
         chk("R2 oe", {31'b0, bus_oe}, 32'd0);
         chk("R2 bus", {16'b0, bus_out}, 32'd0);
      end
      main_m[a] = d;
      side_m[a] = d[SW-1:0];
   endtask

   initial begin
      logic [DW-1:0] last_w;
      repeat (2) @(negedge clk);
      chk("R8 reset side", {30'b0, side_out}, 32'd0);
      rst_n = 1'b1;
      for (int p = 0; p < 3; p++) begin
         for (int a = 0; a < DEPTH; a++) wr(a, pat(p, a));
         last_w = pat(p, DEPTH - 1);
         for (int k = 0; k < DEPTH + 2; k++) begin
            @(negedge clk);
            if (k == 1)
               chk("R7 write-through", {30'b0, side_out}, {30'b0, last_w[SW-1:0]});
            if (k >= 2)
               chk("R4 R5 R6 side", {30'b0, side_out}, {30'b0, side_m[scr(k - 2)]});
            addr = AW'(scr(k % DEPTH)); wr_en = 1'b0;
            #1;
            if (k < DEPTH) begin
               chk("R1 R3 read", {16'b0, bus_out}, {16'b0, main_m[scr(k)]});
               if (k % 64 == 0) chk("R3 oe", {31'b0, bus_oe}, 32'd1);
            end
         end
      end
      // reset between a write and its delayed side update
      wr(77, 16'hBEEF);
      side_m[77] = pat(2, 77) & 2'b11;
      @(negedge clk);
      rst_n = 1'b0; wr_en = 1'b0; addr = 8'd77;
      #1;
      chk("R8 reset clears side_out", {30'b0, side_out}, 32'd0);
      chk("R1 main kept through reset", {16'b0, bus_out}, 32'h0000BEEF);
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk("R8 side write dropped", {30'b0, side_out}, {30'b0, side_m[77]});
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #2000000;
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule